// File: doc/BRIEF.md
# SAR Section Conversion Sequencer

This block runs one successive-approximation converter section through a fixed frame of sixteen clock cycles. Four preparatory cycles come first, in this order: the zero reference is sampled, the comparator is checked against that zero to correct its offset, a second comparison corrects the gain of the reference ladder, and the analog input is sampled. Eleven search cycles follow, one result bit per cycle starting from the most significant bit. A final cycle hands the finished code to the output path. The frame then starts again at once.

The analog comparator, the capacitor DAC and the calibration integrators are outside the block. The sequencer drives a one-hot set of phase strobes that control the analog switches. It presents the trial code to the DAC and takes the comparator decision back as one bit. In the two calibration cycles it turns the comparator decision into up/down pulses. An external integrator accumulates these pulses over many frames, so offset and gain correction build up over time instead of resting on one decision. Several sections can run side by side, offset in time, by pulsing the frame-start strobe for each one at a different cycle.

Top module: `sar_frame_seq`

## Requirements
- R1: After reset, the frame runs through its cycles in a fixed order. Cycle 1 raises `ph_zero`, cycle 2 raises `ph_az`, cycle 3 raises `ph_cal` and cycle 4 raises `ph_samp`. After cycle 16, cycle 1 follows directly, so the frame is 16 cycles long.
- R2: Exactly one of `ph_zero`, `ph_az`, `ph_cal`, `ph_samp`, `ph_conv` and `xfer_stb` is high in every cycle. `ph_conv` is high in cycles 5 to 15 only.
- R3: In the cycle after a `ph_az` cycle, `ofs_up` equals the `cmp` value sampled at the end of that `ph_az` cycle, and `ofs_dn` is its complement. In every other cycle both flags are low.
- R4: In the cycle after a `ph_cal` cycle, `gain_up` equals the `cmp` value sampled at the end of that `ph_cal` cycle, and `gain_dn` is its complement. In every other cycle both flags are low.
- R5: In cycle 5, the first search cycle, `dac_code` has only its most significant bit set (0x400 at 11 bits).
- R6: During a search cycle, the bit under test is 1. At the clock edge that ends the cycle, the bit stays 1 if `cmp` is 1 and is cleared if `cmp` is 0, and the next lower bit is set to 1 as the new trial. `dac_code` is 0 in cycles 1 to 4. With an ideal comparator (`cmp` = input >= `dac_code`), the result equals the input value.
- R7: `result` loads the final code, including the last bit's decision, at the edge that ends cycle 15. It holds that value until the next such load. `xfer_stb` is high for exactly one cycle, cycle 16.
- R8: If `start` is high at a clock edge, the next cycle is cycle 1, with `dac_code` at 0 and all correction flags low. `result` keeps its value.
- R9: If `rst` is high at a clock edge (synchronous reset), the next cycle is cycle 1, with `dac_code`, `result` and all correction flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame-start strobe; restarts the frame at cycle 1 |
| cmp | input | 1 | Comparator decision, 1 when the sampled value is at or above the DAC level |
| ph_zero | output | 1 | Zero-reference sampling strobe (cycle 1) |
| ph_az | output | 1 | Offset comparison strobe (cycle 2) |
| ph_cal | output | 1 | Gain calibration comparison strobe (cycle 3) |
| ph_samp | output | 1 | Input sampling strobe (cycle 4) |
| ph_conv | output | 1 | Search strobe (cycles 5 to 15) |
| xfer_stb | output | 1 | Result transfer strobe (cycle 16) |
| dac_code | output | RES_BITS | Trial code driven to the DAC |
| ofs_up | output | 1 | Offset correction, raise |
| ofs_dn | output | 1 | Offset correction, lower |
| gain_up | output | 1 | Gain correction, raise |
| gain_dn | output | 1 | Gain correction, lower |
| result | output | RES_BITS | Last completed conversion result |

## Verification
The assertions check the following on every cycle. They check the phase order and the wrap from the transfer cycle back to zero sampling. They check that exactly one phase is active. They check that each correction pulse matches the comparator bit sampled one cycle earlier, and that the flags stay quiet outside those pulses. They also check the MSB-only trial at search entry, that the result holds outside the search, and how `start` and reset take effect. Whether the binary search converges to the right code can only be shown by the bench's scenarios. In those scenarios an ideal comparator faces inputs at zero, full scale, the midscale boundary and alternating bit patterns, and frames are cut short by `start` and by reset at chosen cycles.

// File: rtl/sar_frame_pkg.sv
package sar_frame_pkg;

   // Number of preparatory cycles ahead of the search: zero sample,
   // offset compare, gain compare, input sample.
   localparam int PRE_LEN = 4;

   typedef enum logic [2:0] {
      PH_ZERO = 3'd0,
      PH_AZ   = 3'd1,
      PH_CAL  = 3'd2,
      PH_SAMP = 3'd3,
      PH_CONV = 3'd4,
      PH_XFER = 3'd5
   } sar_phase_e;

endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer
   import sar_frame_pkg::*;
#(
   parameter int RES_BITS = 11,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   output sar_phase_e       phase,
   output logic [CNT_W-1:0] step
);

   localparam int FRAME_LEN = PRE_LEN + RES_BITS + 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || start)
         cnt <= '0;
      else if (cnt == LAST)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   always_comb begin
      if (cnt == CNT_W'(0))
         phase = PH_ZERO;
      else if (cnt == CNT_W'(1))
         phase = PH_AZ;
      else if (cnt == CNT_W'(2))
         phase = PH_CAL;
      else if (cnt == CNT_W'(3))
         phase = PH_SAMP;
      else if (cnt == LAST)
         phase = PH_XFER;
      else
         phase = PH_CONV;
   end

   // Search step: 0 on the MSB trial cycle, RES_BITS-1 on the LSB cycle.
   assign step = cnt - CNT_W'(PRE_LEN);

endmodule

// File: rtl/sar_frame_search.sv
module sar_frame_search
   import sar_frame_pkg::*;
#(
   parameter int RES_BITS = 11,
   parameter int CNT_W    = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  sar_phase_e          phase,
   input  logic [CNT_W-1:0]    step,
   input  logic                cmp,
   output logic [RES_BITS-1:0] code,
   output logic [RES_BITS-1:0] result
);

   localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(RES_BITS - 1);

   logic                in_conv;
   logic [RES_BITS-1:0] cur_mask;
   logic [RES_BITS-1:0] nxt_mask;

   assign in_conv = (phase == PH_CONV);

   for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
      // Bit i is under test on step RES_BITS-1-i.
      assign cur_mask[i] = in_conv && (step == CNT_W'(RES_BITS - 1 - i));

      if (i == RES_BITS - 1) begin : g_top
         assign nxt_mask[i] = 1'b0;
      end else begin : g_low
         assign nxt_mask[i] = in_conv && (step == CNT_W'(RES_BITS - 2 - i));
      end

      always_ff @(posedge clk) begin
         if (rst || start)
            code[i] <= 1'b0;
         else if (phase == PH_SAMP)
            code[i] <= (i == RES_BITS - 1);
         else if (phase == PH_XFER)
            code[i] <= 1'b0;
         else if (cur_mask[i])
            code[i] <= cmp;
         else if (nxt_mask[i])
            code[i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         result <= '0;
      else if (!start && in_conv && step == STEP_LAST)
         result <= {code[RES_BITS-1:1], cmp};
   end

endmodule

// File: rtl/sar_frame_corr.sv
module sar_frame_corr
   import sar_frame_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  sar_phase_e phase,
   input  logic       cmp,
   output logic [1:0] up,
   output logic [1:0] dn
);

   // Channel 0 follows the offset compare, channel 1 the gain compare.
   logic [1:0] hit;
   assign hit[0] = (phase == PH_AZ);
   assign hit[1] = (phase == PH_CAL);

   for (genvar j = 0; j < 2; j++) begin : g_ch
      always_ff @(posedge clk) begin
         if (rst || start) begin
            up[j] <= 1'b0;
            dn[j] <= 1'b0;
         end else begin
            up[j] <= hit[j] && cmp;
            dn[j] <= hit[j] && !cmp;
         end
      end
   end

endmodule

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
   import sar_frame_pkg::*;
#(
   parameter int RES_BITS = 11
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                start,
   input  logic                cmp,
   output logic                ph_zero,
   output logic                ph_az,
   output logic                ph_cal,
   output logic                ph_samp,
   output logic                ph_conv,
   output logic                xfer_stb,
   output logic [RES_BITS-1:0] dac_code,
   output logic                ofs_up,
   output logic                ofs_dn,
   output logic                gain_up,
   output logic                gain_dn,
   output logic [RES_BITS-1:0] result
);

   localparam int FRAME_LEN = PRE_LEN + RES_BITS + 1;
   localparam int CNT_W     = $clog2(FRAME_LEN);

   initial begin
      if (RES_BITS < 2)
         $fatal(1, "sar_frame_seq: RES_BITS must be at least 2");
   end

   sar_phase_e       phase;
   logic [CNT_W-1:0] step;
   logic [1:0]       corr_up;
   logic [1:0]       corr_dn;

   sar_frame_timer #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .phase (phase),
      .step  (step)
   );

   sar_frame_search #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) u_search (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .phase  (phase),
      .step   (step),
      .cmp    (cmp),
      .code   (dac_code),
      .result (result)
   );

   sar_frame_corr u_corr (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .phase (phase),
      .cmp   (cmp),
      .up    (corr_up),
      .dn    (corr_dn)
   );

   assign ph_zero  = (phase == PH_ZERO);
   assign ph_az    = (phase == PH_AZ);
   assign ph_cal   = (phase == PH_CAL);
   assign ph_samp  = (phase == PH_SAMP);
   assign ph_conv  = (phase == PH_CONV);
   assign xfer_stb = (phase == PH_XFER);

   assign ofs_up  = corr_up[0];
   assign ofs_dn  = corr_dn[0];
   assign gain_up = corr_up[1];
   assign gain_dn = corr_dn[1];

endmodule

// File: rtl/sar_frame_seq_chk.sv
module sar_frame_seq_chk #(
   parameter int RES_BITS = 11
) (
   input logic                clk,
   input logic                rst,
   input logic                start,
   input logic                cmp,
   input logic                ph_zero,
   input logic                ph_az,
   input logic                ph_cal,
   input logic                ph_samp,
   input logic                ph_conv,
   input logic                xfer_stb,
   input logic [RES_BITS-1:0] dac_code,
   input logic                ofs_up,
   input logic                ofs_dn,
   input logic                gain_up,
   input logic                gain_dn,
   input logic [RES_BITS-1:0] result
);

   localparam logic [RES_BITS-1:0] MSB_ONLY = {1'b1, {(RES_BITS-1){1'b0}}};

   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
      (xfer_stb && !start) |=> ph_zero);  // R1

   AST_ZERO_TO_AZ: assert property (@(posedge clk) disable iff (rst)
      (ph_zero && !start) |=> ph_az);  // R1

   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
      $countones({ph_zero, ph_az, ph_cal, ph_samp, ph_conv, xfer_stb}) == 1);  // R2

   AST_OFS_PULSE: assert property (@(posedge clk) disable iff (rst)
      (ph_az && !start) |=> (ofs_up == $past(cmp)) && (ofs_dn == !$past(cmp)));  // R3

   AST_OFS_QUIET: assert property (@(posedge clk) disable iff (rst)
      !ph_az |=> (!ofs_up && !ofs_dn));  // R3

   AST_GAIN_PULSE: assert property (@(posedge clk) disable iff (rst)
      (ph_cal && !start) |=> (gain_up == $past(cmp)) && (gain_dn == !$past(cmp)));  // R4

   AST_GAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
      !ph_cal |=> (!gain_up && !gain_dn));  // R4

   AST_MSB_TRIAL: assert property (@(posedge clk) disable iff (rst)
      (ph_samp && !start) |=> (dac_code == MSB_ONLY));  // R5

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ph_conv |=> $stable(result));  // R7

   AST_XFER_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (xfer_stb && !start) |=> !xfer_stb);  // R7

   AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
      start |=> (ph_zero && dac_code == '0 && !ofs_up && !ofs_dn && !gain_up && !gain_dn));  // R8

   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (ph_zero && dac_code == '0 && result == '0 && !ofs_up && !gain_up));  // R9

endmodule

bind sar_frame_seq sar_frame_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .start    (start),
   .cmp      (cmp),
   .ph_zero  (ph_zero),
   .ph_az    (ph_az),
   .ph_cal   (ph_cal),
   .ph_samp  (ph_samp),
   .ph_conv  (ph_conv),
   .xfer_stb (xfer_stb),
   .dac_code (dac_code),
   .ofs_up   (ofs_up),
   .ofs_dn   (ofs_dn),
   .gain_up  (gain_up),
   .gain_dn  (gain_dn),
   .result   (result)
);

// File: tb/sar_frame_seq_test.sv
module sar_frame_seq_test;

   localparam int N = 11;

   logic         clk = 1'b0;
   logic         rst_i = 1'b1;
   logic         start_i = 1'b0;
   logic         cmp_i = 1'b0;
   logic         ph_zero, ph_az, ph_cal, ph_samp, ph_conv, xfer_stb;
   logic [N-1:0] dac_code, result;
   logic         ofs_up, ofs_dn, gain_up, gain_dn;

   always #2 clk = ~clk;

   sar_frame_seq #(.RES_BITS(N)) uut (
      .clk      (clk),
      .rst      (rst_i),
      .start    (start_i),
      .cmp      (cmp_i),
      .ph_zero  (ph_zero),
      .ph_az    (ph_az),
      .ph_cal   (ph_cal),
      .ph_samp  (ph_samp),
      .ph_conv  (ph_conv),
      .xfer_stb (xfer_stb),
      .dac_code (dac_code),
      .ofs_up   (ofs_up),
      .ofs_dn   (ofs_dn),
      .gain_up  (gain_up),
      .gain_dn  (gain_dn),
      .result   (result)
   );

   int checks = 0;
   int bad    = 0;
   bit done   = 1'b0;

   // Reference model state: the state the design holds after the next edge.
   int m_pos = 0, m_code = 0, m_res = 0;
   bit m_ou = 0, m_od = 0, m_gu = 0, m_gd = 0;
   bit m_clean = 0, m_after_start = 0, m_after_rst = 0;
   int vin = 0;
   int vq[$];
   logic [15:0] lf = 16'hACE1;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R1 ph_zero", int'(ph_zero), int'(m_pos == 0));
      chk("R1 ph_az", int'(ph_az), int'(m_pos == 1));
      chk("R1 ph_cal", int'(ph_cal), int'(m_pos == 2));
      chk("R1 ph_samp", int'(ph_samp), int'(m_pos == 3));
      chk("R2 ph_conv", int'(ph_conv), int'(m_pos >= 4 && m_pos <= 14));
      chk("R7 xfer_stb", int'(xfer_stb), int'(m_pos == 15));
      chk("R6 dac_code", int'(dac_code), m_code);
      chk("R7 result", int'(result), m_res);
      chk("R3 ofs_up", int'(ofs_up), int'(m_ou));
      chk("R3 ofs_dn", int'(ofs_dn), int'(m_od));
      chk("R4 gain_up", int'(gain_up), int'(m_gu));
      chk("R4 gain_dn", int'(gain_dn), int'(m_gd));
      if (m_pos == 4)
         chk("R5 MSB-only trial", int'(dac_code), 1 << (N-1));
      if (m_pos == 15 && m_clean)
         chk("R6 converged result equals input", int'(result), vin);
      if (m_after_start) begin
         chk("R8 start gives cycle 1", int'(ph_zero), 1);
         chk("R8 start clears code", int'(dac_code), 0);
         m_after_start = 0;
      end
      if (m_after_rst) begin
         chk("R9 reset gives cycle 1", int'(ph_zero), 1);
         chk("R9 reset clears result", int'(result), 0);
         m_after_rst = 0;
      end
   endtask

   task automatic advance();
      if (rst_i) begin
         m_pos = 0; m_code = 0; m_res = 0;
         m_ou = 0; m_od = 0; m_gu = 0; m_gd = 0;
         m_clean = 0; m_after_rst = 1;
      end else if (start_i) begin
         m_pos = 0; m_code = 0;
         m_ou = 0; m_od = 0; m_gu = 0; m_gd = 0;
         m_clean = 0; m_after_start = 1;
      end else begin
         m_ou = (m_pos == 1) && cmp_i;
         m_od = (m_pos == 1) && !cmp_i;
         m_gu = (m_pos == 2) && cmp_i;
         m_gd = (m_pos == 2) && !cmp_i;
         if (m_pos == 2) m_clean = 1;
         if (m_pos == 3) begin
            m_code = 1 << (N-1);
         end else if (m_pos >= 4 && m_pos <= 14) begin
            automatic int k = N - 1 - (m_pos - 4);
            if (!cmp_i) m_code = m_code & ~(1 << k);
            if (k > 0) m_code = m_code | (1 << (k-1));
            else m_res = m_code;
         end else if (m_pos == 15) begin
            m_code = 0;
         end
         m_pos = (m_pos + 1) % 16;
      end
   endtask

   task automatic tick(input logic r, input logic s);
      @(negedge clk);
      compare_all();
      if (m_pos == 0 && vq.size() > 0) vin = vq.pop_front();
      rst_i   = r;
      start_i = s;
      if (m_pos >= 4 && m_pos <= 14) begin
         cmp_i = (vin >= m_code);
      end else begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         cmp_i = lf[0];
      end
      advance();
   endtask

   initial begin
      repeat (3) tick(1'b1, 1'b0);
      vq = '{0, 2047, 1024, 1023, 1, 1365, 682, 1000};
      repeat (16 * 8 + 2) tick(1'b0, 1'b0);
      // start in the middle of the search
      vq = '{777};
      while (m_pos != 7) tick(1'b0, 1'b0);
      tick(1'b0, 1'b1);
      repeat (20) tick(1'b0, 1'b0);
      // start during the transfer cycle
      while (m_pos != 15) tick(1'b0, 1'b0);
      tick(1'b0, 1'b1);
      vq = '{1536, 513};
      repeat (40) tick(1'b0, 1'b0);
      // start during the offset compare cycle
      while (m_pos != 1) tick(1'b0, 1'b0);
      tick(1'b0, 1'b1);
      repeat (20) tick(1'b0, 1'b0);
      // reset in the middle of the search
      while (m_pos != 9) tick(1'b0, 1'b0);
      tick(1'b1, 1'b0);
      vq = '{2046, 5};
      repeat (40) tick(1'b0, 1'b0);
      tick(1'b0, 1'b0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         bad++;
         checks++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule